// File: doc/BRIEF.md
# Recirculating Vector Pattern Generator

This block produces the one data bit that goes with each pixel write when lines are drawn one pixel at a time. It keeps a short bit pattern in a ring register that rotates by one place on each advance. The current bit is always at the low end of the ring. A small repeat value sets how many write cycles each pattern bit is held. The same stored pattern can therefore draw fine dashes or stretched dashes.

Software first writes the repeat value and then writes the pattern. After that, the drawing engine pulses a strobe once per pixel write. The output bit changes only when a strobe completes a hold period. Clocks with no strobe leave the output and the hold progress unchanged. Either register can be rewritten at any time. A rewrite takes effect immediately on the line already being drawn.

Top module: `vec_pattern_gen`

## Requirements
- R1: After reset the pattern ring, the repeat value and the hold counter are all zero, so `pix_out` is 0.
- R2: `pix_out` always equals bit 0 of the pattern ring. A pattern load makes `pix_out` equal `pat_data[0]` from the next clock onward.
- R3: Each advance rotates the ring right by one place, and the old bit 0 moves into the top bit. With an 8-bit ring, the bits appear in the order 0,1,...,7 and then bit 0 appears again.
- R4: With repeat value r (0..15), each pattern bit is held for 16 − r strobes. For example, r=15 advances on every strobe, r=12 advances every 4 strobes, r=5 advances every 11 strobes, and r=0 advances every 16 strobes.
- R5: The ring and the hold counter change only on a clock where `wr_stb` is high. On idle clocks the output and the hold progress do not change.
- R6: A pattern load clears the hold counter, so the first bit gets its full hold. A strobe on the same clock as a pattern load is ignored.
- R7: A repeat load takes effect on the next strobe and does not clear the hold counter. If the counter has already reached the new limit, the next strobe advances the ring.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pat_load | input | 1 | Write `pat_data` into the pattern ring |
| pat_data | input | 8 | New pattern value |
| rep_load | input | 1 | Write `rep_data` into the repeat register |
| rep_data | input | 4 | New repeat value (hold = 16 − value) |
| wr_stb | input | 1 | One pulse per pixel write cycle |
| pix_out | output | 1 | Pattern bit for the current write |

## Verification
The bound checker runs on every cycle. It checks that an advance happens only on a strobe, that an advance rotates the ring by exactly one place, and that idle cycles leave the counter and the output untouched. It also checks that a pattern load shows the new low bit on the next clock and clears the counter. The exact hold length for each repeat value, the effect of a repeat reload in the middle of a hold, and the full bit order over several loops depend on a history of strobes. Only the bench shows these, by comparing the output stream with a model computed from the strobe count for every repeat value and several patterns.

// File: rtl/vpg_pkg.sv
package vpg_pkg;
   // Divider compare limit: hold of (2**rep_w - rep) strobes means
   // advancing when the counter reaches (2**rep_w - 1 - rep).
   function automatic int unsigned hold_limit(input int unsigned rep,
                                              input int unsigned rep_w);
      return ((1 << rep_w) - 1) - rep;
   endfunction
endpackage

// File: rtl/vpg_ring.sv
module vpg_ring #(
   parameter int PAT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [PAT_W-1:0] load_val,
   input  logic             advance,
   output logic [PAT_W-1:0] ring_q
);
   logic [PAT_W-1:0] rot;

   generate
      if (PAT_W < 2) begin : g_bad_width
         $error("vpg_ring: PAT_W must be at least 2");
      end
      for (genvar i = 0; i < PAT_W; i++) begin : g_rot
         if (i == PAT_W - 1) begin : g_top
            assign rot[i] = ring_q[0];
         end else begin : g_mid
            assign rot[i] = ring_q[i+1];
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)       ring_q <= '0;
      else if (load)    ring_q <= load_val;
      else if (advance) ring_q <= rot;
   end
endmodule

// File: rtl/vpg_divider.sv
module vpg_divider #(
   parameter int REP_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             step,
   input  logic             rep_load,
   input  logic [REP_W-1:0] rep_data,
   output logic             advance,
   output logic [REP_W-1:0] cnt_q
);
   import vpg_pkg::*;

   localparam logic [REP_W-1:0] CNT_MAX = {REP_W{1'b1}};

   logic [REP_W-1:0] rep_q;
   logic [REP_W-1:0] limit;

   generate
      if (REP_W < 1 || REP_W > 16) begin : g_bad_width
         $error("vpg_divider: REP_W out of range");
      end
   endgenerate

   assign limit   = CNT_MAX - rep_q;
   assign advance = step && (cnt_q >= limit);

   always_ff @(posedge clk) begin
      if (!rst_n)        rep_q <= '0;
      else if (rep_load) rep_q <= rep_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       cnt_q <= '0;
      else if (clr)     cnt_q <= '0;
      else if (advance) cnt_q <= '0;
      else if (step)    cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/vec_pattern_gen.sv
module vec_pattern_gen #(
   parameter int PAT_W = 8,
   parameter int REP_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pat_load,
   input  logic [PAT_W-1:0] pat_data,
   input  logic             rep_load,
   input  logic [REP_W-1:0] rep_data,
   input  logic             wr_stb,
   output logic             pix_out
);
   logic [PAT_W-1:0] ring_q;
   logic [REP_W-1:0] cnt_q;
   logic             advance;
   logic             step;

   // a load takes the cycle; a coincident strobe is dropped
   assign step = wr_stb && !pat_load;

   vpg_divider #(.REP_W(REP_W)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (pat_load),
      .step    (step),
      .rep_load(rep_load),
      .rep_data(rep_data),
      .advance (advance),
      .cnt_q   (cnt_q)
   );

   vpg_ring #(.PAT_W(PAT_W)) u_ring (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (pat_load),
      .load_val(pat_data),
      .advance (advance),
      .ring_q  (ring_q)
   );

   assign pix_out = ring_q[0];
endmodule

// File: rtl/vpg_checker.sv
module vpg_checker #(
   parameter int PAT_W = 8,
   parameter int REP_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             pat_load,
   input logic [PAT_W-1:0] pat_data,
   input logic             wr_stb,
   input logic             pix_out,
   input logic             advance,
   input logic [PAT_W-1:0] ring_q,
   input logic [REP_W-1:0] cnt_q
);
   // R1
   reset_clear_chk: assert property (@(posedge clk)
      !rst_n |=> (ring_q == '0 && cnt_q == '0 && !pix_out));

   // R2
   load_shows_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pat_load |=> (pix_out == $past(pat_data[0]) && ring_q == $past(pat_data)));

   // R3
   rotate_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && !pat_load) |=>
         ring_q == {$past(ring_q[0]), $past(ring_q[PAT_W-1:1])});

   // R5
   advance_needs_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      advance |-> wr_stb);

   // R5
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_stb && !pat_load) |=> ($stable(cnt_q) && $stable(pix_out)));

   // R6
   load_clears_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pat_load |=> cnt_q == '0);
endmodule

bind vec_pattern_gen vpg_checker #(.PAT_W(PAT_W), .REP_W(REP_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .pat_load(pat_load),
   .pat_data(pat_data),
   .wr_stb  (wr_stb),
   .pix_out (pix_out),
   .advance (advance),
   .ring_q  (ring_q),
   .cnt_q   (cnt_q)
);

// File: tb/sim_vec_pattern_gen.sv
module sim_vec_pattern_gen;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pat_load = 1'b0;
   logic [7:0] pat_data = '0;
   logic       rep_load = 1'b0;
   logic [3:0] rep_data = '0;
   logic       wr_stb = 1'b0;
   logic       pix_out;

   int checks = 0;
   int errors = 0;

   localparam int NPAT = 6;
   localparam logic [7:0] PATS [NPAT] = '{8'hFF, 8'h00, 8'hAA, 8'h55, 8'h96, 8'h01};

   always #10 clk = ~clk;

   vec_pattern_gen u0 (
      .clk(clk), .rst_n(rst_n), .pat_load(pat_load), .pat_data(pat_data),
      .rep_load(rep_load), .rep_data(rep_data), .wr_stb(wr_stb), .pix_out(pix_out)
   );

   task automatic check(input string req, input logic exp);
      checks++;
      if (pix_out !== exp) begin
         errors++;
         $display("FAIL %s: pix_out=%0b expected %0b at %0t", req, pix_out, exp, $time);
      end
   endtask

   // one clock; inputs change just after an edge, outputs sampled there too
   task automatic tick(input logic stb);
      wr_stb = stb;
      @(posedge clk); #1;
      wr_stb = 1'b0; pat_load = 1'b0; rep_load = 1'b0;
   endtask

   task automatic load_rep(input logic [3:0] r);
      rep_load = 1'b1; rep_data = r; tick(1'b0);
   endtask

   task automatic load_pat(input logic [7:0] p);
      pat_load = 1'b1; pat_data = p; tick(1'b0);
   endtask

   initial begin
      #(20 * 150000);
      errors++;
      $display("FAIL watchdog: run hung, actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      @(posedge clk); #1;
      tick(1'b0); tick(1'b0);
      // R1: reset state
      check("R1", 1'b0);
      rst_n = 1'b1;
      tick(1'b1);
      check("R1", 1'b0);

      // R2 R3 R4 R5: stream for every repeat value and pattern
      for (int pi = 0; pi < NPAT; pi++) begin
         for (int r = 0; r < 16; r++) begin
            int hold;
            hold = 16 - r;
            load_rep(4'(r));
            load_pat(PATS[pi]);
            for (int n = 0; n < 9 * hold; n++) begin
               check("R4", PATS[pi][(n / hold) % 8]);
               if (n % 5 == 2) begin
                  tick(1'b0);
                  check("R5", PATS[pi][(n / hold) % 8]);
               end
               tick(1'b1);
            end
         end
      end

      // R3: wrap after bit 7 with hold 1
      load_rep(4'd15);
      load_pat(8'b1000_0001);
      for (int n = 0; n < 7; n++) tick(1'b1);
      check("R3", 1'b1);
      tick(1'b1);
      check("R3", 1'b1);
      tick(1'b1);
      check("R3", 1'b0);

      // R7: repeat reload mid-hold, counter kept
      load_rep(4'd12);
      load_pat(8'hF2);
      tick(1'b1); tick(1'b1);
      check("R7", 1'b0);
      load_rep(4'd14);
      check("R7", 1'b0);
      tick(1'b1);
      check("R7", 1'b1);
      tick(1'b1);
      check("R7", 1'b1);
      tick(1'b1);
      check("R7", 1'b0);

      // R6: pattern reload mid-hold restarts full hold
      load_rep(4'd13);
      load_pat(8'hFE);
      tick(1'b1); tick(1'b1);
      load_pat(8'h02);
      check("R6", 1'b0);
      tick(1'b1); tick(1'b1);
      check("R6", 1'b0);
      tick(1'b1);
      check("R6", 1'b1);

      // R6: strobe coinciding with a load is dropped
      load_rep(4'd15);
      pat_load = 1'b1; pat_data = 8'h01;
      tick(1'b1);
      check("R6", 1'b1);
      tick(1'b1);
      check("R6", 1'b0);

      // R1: reset in mid-pattern clears everything
      load_pat(8'hFF);
      rst_n = 1'b0;
      tick(1'b0);
      rst_n = 1'b1;
      check("R1", 1'b0);
      tick(1'b1);
      check("R1", 1'b0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule